// File: doc/BRIEF.md
# Channel Hit Auto-Reset Controller

This block sequences what each detector channel does after its discriminator fires. An accepted firing sets the channel's hit flag and opens an output pulse of fixed width. When that pulse ends, a delay starts whose length is a cycle count shared by every channel. When the delay runs out, the channel drops its hit and active flags and sends one-cycle reset strobes to its time converter and its peak sampler. The exception is a veto held high on every cycle of the delay, which makes the channel keep its data.

Two global controls take precedence over the per-channel sequence. A force-reset input clears all channels and strobes all their converters. An acquire-all input marks every channel as hit without starting its timing. A firing is accepted only when both the per-channel enable and the global enable are high. A firing that arrives while the channel is already hit or still timing is ignored. All timing is done by clock-cycle counters.

Top module: `hit_reset_ctrl`

## Requirements
- R1: While and after reset, with no stimulus, every bit of `hit`, `active`, `pulse_out`, `tvc_rst` and `psamp_rst` is 0.
- R2: A rising edge on `fire[i]` is accepted when the channel is idle with hit clear and both enables are high. `hit[i]` is 1 after the next clock edge, and `pulse_out[i]` is high for exactly PULSE_W consecutive cycles starting with that same edge.
- R3: A firing is ignored (hit stays 0, no pulse) when `ch_en[i]` is 0 or `glb_en` is 0.
- R4: After the pulse ends, the delay lasts `dly_cycles` cycles (a value of 0 counts as 1). If the delay is not vetoed, `hit[i]` and `active[i]` go to 0 and `tvc_rst[i]` and `psamp_rst[i]` are high for exactly one cycle. Both effects appear at the clock edge that comes PULSE_W + `dly_cycles` edges after the edge that set hit.
- R5: If `veto` is 1 on every clock edge of the delay window, the automatic reset is suppressed: hit stays 1 and no strobe is issued.
- R6: If `veto` is 0 on any single edge of the delay window, the automatic reset happens at its normal time.
- R7: A clock edge that samples `force_rst` high clears hit and active in all channels, returns them to idle, and raises both strobes of every channel for the following cycle. `force_rst` takes precedence over every other input.
- R8: A clock edge that samples `acq_all` high (with `force_rst` low) sets hit in every channel without producing a pulse.
- R9: A firing that arrives while the channel is in its pulse or delay phase, or is idle with hit set, is ignored. The pulse is not extended and the reset timing is unchanged.
- R10: `act_set[i]` sets `active[i]` only if `hit[i]` is already 1. Active is cleared together with hit.
- R11: A `fire[i]` held high counts as one firing. It does not fire again after the automatic reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire | input | NUM_CH | Discriminator outputs, one per channel; rising edge is a firing |
| ch_en | input | NUM_CH | Per-channel discriminator enable |
| glb_en | input | 1 | Global discriminator enable, ANDed with each channel enable |
| veto | input | 1 | Global veto of the automatic reset |
| force_rst | input | 1 | Global forced reset of all channels |
| acq_all | input | 1 | Global set of all hit flags |
| act_set | input | NUM_CH | Sets the active flag of a channel that is hit |
| dly_cycles | input | DLY_W | Shared post-pulse delay in clock cycles |
| hit | output | NUM_CH | Hit flags |
| active | output | NUM_CH | Active flags |
| pulse_out | output | NUM_CH | Fixed-width pulse per channel |
| tvc_rst | output | NUM_CH | One-cycle reset strobe to each time converter |
| psamp_rst | output | NUM_CH | One-cycle reset strobe to each peak sampler |

## Verification
The assertions assume that `dly_cycles` stays constant while any channel is timing. The bench sets it once, before the first firing. They also assume that acquire-all and force-reset are the only things that change hit outside the sequence. The strobe-source property therefore excludes cycles that follow either of those inputs, and the bench drives them only in scenarios of their own. Veto is always driven a half cycle before the edge that samples it, and the glitch case drops it for exactly one edge inside the delay window.

// File: rtl/hit_reset_ctrl_pkg.sv
package hit_reset_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_DELAY = 2'd2
  } hrc_state_e;
endpackage

// File: rtl/hrc_fire_gate.sv
// Turns raw discriminator levels into qualified single-cycle firing requests.
module hrc_fire_gate #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              glb_en,
  output logic [NUM_CH-1:0] fire_ok
);
  logic [NUM_CH-1:0] fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire_q <= '0;
    else        fire_q <= fire;
  end

  always_comb begin
    fire_ok = fire & ~fire_q & ch_en & {NUM_CH{glb_en}};
  end
endmodule

// File: rtl/hrc_chan.sv
// One channel: pulse phase, shared delay phase, veto-qualified auto reset.
module hrc_chan
  import hit_reset_ctrl_pkg::*;
#(
  parameter int PULSE_W = 13,
  parameter int DLY_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_ok,
  input  logic             veto,
  input  logic             force_rst,
  input  logic             acq_all,
  input  logic             act_set,
  input  logic [DLY_W-1:0] dly_cycles,
  output logic             hit,
  output logic             active,
  output logic             pulse_out,
  output logic             rst_strobe
);
  localparam logic [DLY_W-1:0] PULSE_LAST = DLY_W'(PULSE_W - 1);
  localparam logic [DLY_W-1:0] ONE        = DLY_W'(1);

  hrc_state_e       st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             hit_q, hit_d;
  logic             act_q, act_d;
  logic             vok_q, vok_d;
  logic             strb_q, strb_d;
  logic [DLY_W-1:0] dly_last;

  always_comb begin
    dly_last = (dly_cycles == '0) ? '0 : (dly_cycles - ONE);
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    hit_d  = hit_q;
    act_d  = act_q;
    vok_d  = vok_q;
    strb_d = 1'b0;
    if (force_rst) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      hit_d  = 1'b0;
      act_d  = 1'b0;
      vok_d  = 1'b0;
      strb_d = 1'b1;
    end else begin
      if (act_set && hit_q) act_d = 1'b1;
      unique case (st_q)
        ST_IDLE: begin
          if (fire_ok && !hit_q) begin
            st_d  = ST_PULSE;
            cnt_d = '0;
            hit_d = 1'b1;
          end
        end
        ST_PULSE: begin
          if (cnt_q == PULSE_LAST) begin
            st_d  = ST_DELAY;
            cnt_d = '0;
            vok_d = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        ST_DELAY: begin
          vok_d = vok_q & veto;
          if (cnt_q == dly_last) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
            if (!(vok_q && veto)) begin
              hit_d  = 1'b0;
              act_d  = 1'b0;
              strb_d = 1'b1;
            end
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
      if (acq_all) hit_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      hit_q  <= 1'b0;
      act_q  <= 1'b0;
      vok_q  <= 1'b0;
      strb_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      hit_q  <= hit_d;
      act_q  <= act_d;
      vok_q  <= vok_d;
      strb_q <= strb_d;
    end
  end

  always_comb begin
    hit        = hit_q;
    active     = act_q;
    pulse_out  = (st_q == ST_PULSE);
    rst_strobe = strb_q;
  end
endmodule

// File: rtl/hit_reset_ctrl.sv
module hit_reset_ctrl #(
  parameter int NUM_CH  = 4,
  parameter int PULSE_W = 13,
  parameter int DLY_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] fire,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic              glb_en,
  input  logic              veto,
  input  logic              force_rst,
  input  logic              acq_all,
  input  logic [NUM_CH-1:0] act_set,
  input  logic [DLY_W-1:0]  dly_cycles,
  output logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] active,
  output logic [NUM_CH-1:0] pulse_out,
  output logic [NUM_CH-1:0] tvc_rst,
  output logic [NUM_CH-1:0] psamp_rst
);
  logic [NUM_CH-1:0] fire_ok;
  logic [NUM_CH-1:0] strobe;

  hrc_fire_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .ch_en   (ch_en),
    .glb_en  (glb_en),
    .fire_ok (fire_ok)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    hrc_chan #(.PULSE_W(PULSE_W), .DLY_W(DLY_W)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_ok    (fire_ok[i]),
      .veto       (veto),
      .force_rst  (force_rst),
      .acq_all    (acq_all),
      .act_set    (act_set[i]),
      .dly_cycles (dly_cycles),
      .hit        (hit[i]),
      .active     (active[i]),
      .pulse_out  (pulse_out[i]),
      .rst_strobe (strobe[i])
    );
  end

  always_comb begin
    tvc_rst   = strobe;
    psamp_rst = strobe;
  end
endmodule

// File: rtl/hit_reset_ctrl_chk.sv
module hit_reset_ctrl_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              force_rst,
  input logic              acq_all,
  input logic [NUM_CH-1:0] hit,
  input logic [NUM_CH-1:0] active,
  input logic [NUM_CH-1:0] pulse_out,
  input logic [NUM_CH-1:0] tvc_rst
);
  // R7: a sampled force-reset leaves every flag clear
  p_force_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (hit == '0 && active == '0));

  // R8: acquire-all alone sets every hit flag
  p_acq_all_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_all && !force_rst) |=> (&hit));

  // R10: active never stands without hit
  p_active_needs_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active & ~hit) == '0);

  // R2: a pulse only runs in a hit channel
  p_pulse_in_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_out & ~hit) == '0);

  // R4: outside the global overrides a strobe marks a falling hit flag
  p_strobe_on_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(force_rst) && !$past(acq_all)) |->
      ((tvc_rst & ~($past(hit) & ~hit)) == '0));
endmodule

bind hit_reset_ctrl hit_reset_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .force_rst (force_rst),
  .acq_all   (acq_all),
  .hit       (hit),
  .active    (active),
  .pulse_out (pulse_out),
  .tvc_rst   (tvc_rst)
);

// File: tb/hit_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module hit_reset_ctrl_tb_top;
  localparam int NUM_CH  = 4;
  localparam int PULSE_W = 13;
  localparam int DLY_W   = 16;
  localparam int DLY     = 20;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NUM_CH-1:0] fire, ch_en, act_set;
  logic              glb_en, veto, force_rst, acq_all;
  logic [DLY_W-1:0]  dly_cycles;
  logic [NUM_CH-1:0] hit, active, pulse_out, tvc_rst, psamp_rst;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  hit_reset_ctrl #(.NUM_CH(NUM_CH), .PULSE_W(PULSE_W), .DLY_W(DLY_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ch_en(ch_en), .glb_en(glb_en),
    .veto(veto), .force_rst(force_rst), .acq_all(acq_all), .act_set(act_set),
    .dly_cycles(dly_cycles), .hit(hit), .active(active), .pulse_out(pulse_out),
    .tvc_rst(tvc_rst), .psamp_rst(psamp_rst)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_force();
    @(negedge clk); force_rst = 1'b1;
    @(negedge clk); force_rst = 1'b0;
    @(negedge clk);
  endtask

  // mode 0: no veto, 1: veto held, 2: veto dropped once,
  // 3: refire during pulse and delay, 4: fire held high throughout
  task automatic run_seq(input int ch, input int mode);
    int pulse_cnt = 0, strb_cnt = 0, strb_idx = -1, both_ok = 1;
    @(negedge clk);
    if (mode == 1 || mode == 2) veto = 1'b1;
    fire[ch] = 1'b1;
    for (int k = 0; k <= PULSE_W + DLY + 3; k++) begin
      @(negedge clk);
      if (k == 0) check("R2 hit set", int'(hit[ch]), 1);
      if (k == 0 && mode != 4) fire[ch] = 1'b0;
      if (pulse_out[ch]) pulse_cnt++;
      if (tvc_rst[ch]) begin
        strb_cnt++;
        if (strb_idx < 0) strb_idx = k;
      end
      if (tvc_rst[ch] != psamp_rst[ch]) both_ok = 0;
      if (k == 1) act_set[ch] = 1'b1;
      if (k == 2) act_set[ch] = 1'b0;
      if (k == 3) check("R10 active set when hit", int'(active[ch]), 1);
      if (mode == 2 && k == PULSE_W + 2) veto = 1'b0;
      if (mode == 2 && k == PULSE_W + 3) veto = 1'b1;
      if (mode == 3 && (k == 2 || k == PULSE_W + 2)) fire[ch] = 1'b1;
      if (mode == 3 && (k == 3 || k == PULSE_W + 3)) fire[ch] = 1'b0;
      if (k == PULSE_W + DLY && mode != 1)
        check("R4 hit cleared at delay end", int'(hit[ch]), 0);
    end
    fire[ch] = 1'b0;
    veto     = 1'b0;
    check("R2 pulse width", pulse_cnt, PULSE_W);
    check("R4 strobes equal", both_ok, 1);
    if (mode == 1) begin
      check("R5 veto suppresses strobe", strb_cnt, 0);
      check("R5 hit kept", int'(hit[ch]), 1);
      check("R5 active kept", int'(active[ch]), 1);
    end else begin
      check("R4 strobe count", strb_cnt, 1);
      check("R4 strobe cycle", strb_idx, PULSE_W + DLY);
      check("R4 active cleared", int'(active[ch]), 0);
      if (mode == 2) check("R6 veto glitch resets", int'(hit[ch]), 0);
      if (mode == 3) check("R9 refire ignored", strb_idx, PULSE_W + DLY);
      if (mode == 4) check("R11 held fire no retrigger", int'(hit[ch]), 0);
    end
    do_force();
  endtask

  task automatic t_reset();
    check("R1 hit", int'(hit), 0);
    check("R1 active", int'(active), 0);
    check("R1 pulse", int'(pulse_out), 0);
    check("R1 strobes", int'(tvc_rst | psamp_rst), 0);
  endtask

  task automatic t_disabled();
    @(negedge clk); ch_en[1] = 1'b0; fire[1] = 1'b1;
    @(negedge clk); fire[1] = 1'b0;
    check("R3 channel enable off", int'(hit[1]), 0);
    ch_en[1] = 1'b1; glb_en = 1'b0; fire[2] = 1'b1;
    @(negedge clk); fire[2] = 1'b0;
    check("R3 global enable off", int'(hit[2]), 0);
    check("R3 no pulse", int'(pulse_out), 0);
    glb_en = 1'b1;
  endtask

  task automatic t_act_no_hit();
    @(negedge clk); act_set[3] = 1'b1;
    @(negedge clk); act_set[3] = 1'b0;
    check("R10 active needs hit", int'(active[3]), 0);
  endtask

  task automatic t_acq_force();
    @(negedge clk); acq_all = 1'b1;
    @(negedge clk); acq_all = 1'b0;
    check("R8 all hit", int'(hit), (1 << NUM_CH) - 1);
    check("R8 no pulse", int'(pulse_out), 0);
    fire[0] = 1'b1;
    @(negedge clk); fire[0] = 1'b0;
    check("R9 fire while hit idle", int'(pulse_out[0]), 0);
    force_rst = 1'b1;
    @(negedge clk); force_rst = 1'b0;
    check("R7 hit cleared", int'(hit), 0);
    check("R7 strobes all", int'(tvc_rst & psamp_rst), (1 << NUM_CH) - 1);
    @(negedge clk);
    check("R7 strobe one cycle", int'(tvc_rst), 0);
    acq_all = 1'b1; force_rst = 1'b1;
    @(negedge clk); acq_all = 1'b0; force_rst = 1'b0;
    check("R7 force beats acquire-all", int'(hit), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fire = '0; ch_en = '1; act_set = '0; glb_en = 1'b1;
    veto = 1'b0; force_rst = 1'b0; acq_all = 1'b0; dly_cycles = DLY_W'(DLY);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_act_no_hit();
    run_seq(0, 0);
    run_seq(1, 1);
    run_seq(2, 2);
    run_seq(3, 3);
    run_seq(0, 4);
    t_acq_force();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule